// File: doc/BRIEF.md
# Write-Burst Interrupting Read Sequencer

This block sits in a DDR SDRAM controller between the command scheduler and the command/data pins. It issues a write command, runs the write data cycles, and lets a read request to any bank cut the burst short once the minimum write-to-read spacing has passed. When the read goes out, the sequencer masks the data cycle that lines up with the read command and every data cycle after it. It also drops the output enable for the data and strobe pins, so the bus is free well before the read data comes back. A read aimed at a burst that carries auto-precharge is refused: an error flag pulses once, and the request is held until the burst has ended.

Time is counted in controller clock cycles. Each data cycle carries two beats, a rising one and a falling one, and `dm` carries one mask bit for each. Burst length and CAS latency are runtime settings and are latched when a command is issued. The write data starts one cycle after the write command.

The state machine has four states. `ST_IDLE` accepts commands. `ST_WR_GAP` is the first data cycle, where a read is never allowed. `ST_WR_DATA` covers the later data cycles, where a read may interrupt. `ST_TURN` blocks the bus for the turnaround and the returning read data. The transitions are:
- IDLE→WR_GAP when a write is issued.
- IDLE→TURN when a read is issued.
- WR_GAP→IDLE for a one-cycle burst, otherwise WR_GAP→WR_DATA.
- WR_DATA→TURN when an interrupting read is issued.
- WR_DATA→IDLE after the last data cycle.
- TURN→IDLE when the turnaround count runs out.

Top module: `wr_intr_rd_seq`

## Requirements
- R1: The `cfg_bl` encoding is 0 = 2 beats (1 data cycle), 1 = 4 beats (2 cycles), 2 or 3 = 8 beats (4 cycles). A write is issued (`cmd_wr` high) in an idle cycle where `wr_valid` is high and `rd_valid` is low. For an uninterrupted burst, the data cycles are the 1st through the Nth cycle after the write, each with `dq_oe`=1 and `dm`=2'b00.
- R2: A read is never issued in the cycle right after a write. A read requested in that cycle is held (`rd_ready`=0) and goes out in the second cycle after the write.
- R3: A legal read requested during the later data cycles is issued in the cycle it is requested. Every data cycle before that cycle stays unmasked and driven.
- R4: The data cycle that coincides with the interrupting read, and every later data cycle of that burst, carry `dm`=2'b11.
- R5: `dq_oe` is low in the cycle the read is issued and stays low after it. This is at least one cycle before read data at any CAS latency.
- R6: If the write was issued with `wr_ap`=1, a read request during its data cycles pulses `rd_err` for exactly one cycle. That pulse comes in the first cycle of the request. The read is held until the burst ends and is issued in the following idle cycle.
- R7: After any read, `wr_ready` and `rd_ready` stay low for ceil(CAS)+N cycles. The `cfg_cl` encoding is 0 = 2, 1 = 2.5, 2 or 3 = 3. Only one read per write burst is therefore taken.
- R8: In the idle state, a read request has priority over a simultaneous write request, and `cmd_bank` carries `rd_bank` for a read.
- R9: After reset the block is idle: `wr_ready`=`rd_ready`=1, `dm`=2'b11, `dq_oe`=0, and no command or error strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bl | input | 2 | Burst length select |
| cfg_cl | input | 2 | CAS latency select |
| wr_valid | input | 1 | Write request |
| wr_ap | input | 1 | Write carries auto-precharge |
| wr_bank | input | BANK_W | Write bank |
| rd_valid | input | 1 | Read request, held until issued |
| rd_bank | input | BANK_W | Read bank |
| wr_ready | output | 1 | Write can be issued this cycle |
| rd_ready | output | 1 | Read can be issued this cycle |
| cmd_wr | output | 1 | Write command strobe |
| cmd_rd | output | 1 | Read command strobe |
| cmd_bank | output | BANK_W | Bank of the issued command |
| dm | output | 2 | Mask for the rising and falling beat |
| dq_oe | output | 1 | Drive enable for data and strobe pins |
| rd_err | output | 1 | Illegal interrupt of an auto-precharge write |

## Verification
The assertions take for granted several properties of the inputs:
- The configuration is steady around a command.
- A read request, once raised, stays up until `cmd_rd` is seen.
- Write requests arrive only while the block is idle, with no read pending.

The bench follows these rules. It raises a single write, then raises the read at a chosen offset and holds it until it is issued. The sweep covers every burst length, every CAS latency, both auto-precharge settings, and every read offset from the first data cycle to the cycle after the burst.

// File: rtl/wir_pkg.sv
package wir_pkg;
    localparam int CNT_W = 4;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_GAP,
        ST_WR_DATA,
        ST_TURN
    } wir_state_e;
endpackage

// File: rtl/wir_cfg_decode.sv
module wir_cfg_decode #(
    parameter int CNT_W = 4
) (
    input  logic [1:0]       cfg_bl,
    input  logic [1:0]       cfg_cl,
    output logic [CNT_W-1:0] data_cyc,
    output logic [CNT_W-1:0] turn_cyc
);
    logic [CNT_W-1:0] cl_cyc;

    always_comb begin
        unique case (cfg_bl)
            2'd0:    data_cyc = CNT_W'(1);
            2'd1:    data_cyc = CNT_W'(2);
            default: data_cyc = CNT_W'(4);
        endcase
        // half-cycle latency rounds up to a whole cycle of bus hold
        cl_cyc   = (cfg_cl == 2'd0) ? CNT_W'(2) : CNT_W'(3);
        turn_cyc = cl_cyc + data_cyc;
    end
endmodule

// File: rtl/wir_ctrl.sv
module wir_ctrl
    import wir_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  data_cyc,
    input  logic [CNT_W-1:0]  turn_cyc,
    input  logic              wr_valid,
    input  logic              wr_ap,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic              rd_valid,
    input  logic [BANK_W-1:0] rd_bank,
    output logic              wr_ready,
    output logic              rd_ready,
    output logic              cmd_wr,
    output logic              cmd_rd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [1:0]        dm,
    output logic              dq_oe,
    output logic              rd_err
);
    wir_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] nc_q, turn_q;
    logic             ap_q, err_done_q;

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            nc_q       <= CNT_W'(1);
            turn_q     <= CNT_W'(3);
            ap_q       <= 1'b0;
            err_done_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (cmd_wr) begin
                nc_q       <= data_cyc;
                turn_q     <= turn_cyc;
                ap_q       <= wr_ap;
                err_done_q <= 1'b0;
            end else if (rd_err) begin
                err_done_q <= 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        wr_ready = 1'b0;
        rd_ready = 1'b0;
        cmd_wr   = 1'b0;
        cmd_rd   = 1'b0;
        cmd_bank = wr_bank;
        dm       = 2'b11;
        dq_oe    = 1'b0;
        rd_err   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_ready = 1'b1;
                rd_ready = 1'b1;
                if (rd_valid) begin
                    cmd_rd   = 1'b1;
                    cmd_bank = rd_bank;
                    cnt_d    = turn_cyc;
                    state_d  = ST_TURN;
                end else if (wr_valid) begin
                    cmd_wr  = 1'b1;
                    cnt_d   = '0;
                    state_d = ST_WR_GAP;
                end
            end
            ST_WR_GAP: begin
                dm     = 2'b00;
                dq_oe  = 1'b1;
                rd_err = rd_valid && ap_q && !err_done_q;
                if (nc_q == CNT_W'(1)) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d   = CNT_W'(1);
                    state_d = ST_WR_DATA;
                end
            end
            ST_WR_DATA: begin
                rd_ready = !ap_q;
                rd_err   = rd_valid && ap_q && !err_done_q;
                if (rd_valid && !ap_q) begin
                    cmd_rd   = 1'b1;
                    cmd_bank = rd_bank;
                    cnt_d    = turn_q;
                    state_d  = ST_TURN;
                end else begin
                    dm    = 2'b00;
                    dq_oe = 1'b1;
                    if (cnt_q == nc_q - CNT_W'(1)) begin
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_TURN: begin
                if (cnt_q <= CNT_W'(1)) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    p_no_rd_after_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !cmd_rd);
    p_oe_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (dm == 2'b00));
    p_release_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> !dq_oe);
    p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> !rd_err);
    p_err_no_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> !cmd_rd);
    p_turn_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> (!wr_ready && !rd_ready));
    p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_rd && cmd_wr));
endmodule

// File: rtl/wr_intr_rd_seq.sv
module wr_intr_rd_seq
    import wir_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_bl,
    input  logic [1:0]        cfg_cl,
    input  logic              wr_valid,
    input  logic              wr_ap,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic              rd_valid,
    input  logic [BANK_W-1:0] rd_bank,
    output logic              wr_ready,
    output logic              rd_ready,
    output logic              cmd_wr,
    output logic              cmd_rd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [1:0]        dm,
    output logic              dq_oe,
    output logic              rd_err
);
    logic [CNT_W-1:0] data_cyc, turn_cyc;

    wir_cfg_decode #(.CNT_W(CNT_W)) dec_i (
        .cfg_bl  (cfg_bl),
        .cfg_cl  (cfg_cl),
        .data_cyc(data_cyc),
        .turn_cyc(turn_cyc)
    );

    wir_ctrl #(.BANK_W(BANK_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_cyc(data_cyc),
        .turn_cyc(turn_cyc),
        .wr_valid(wr_valid),
        .wr_ap   (wr_ap),
        .wr_bank (wr_bank),
        .rd_valid(rd_valid),
        .rd_bank (rd_bank),
        .wr_ready(wr_ready),
        .rd_ready(rd_ready),
        .cmd_wr  (cmd_wr),
        .cmd_rd  (cmd_rd),
        .cmd_bank(cmd_bank),
        .dm      (dm),
        .dq_oe   (dq_oe),
        .rd_err  (rd_err)
    );
endmodule

// File: tb/wr_intr_rd_seq_tb_top.sv
module wr_intr_rd_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_bl = 2'd0, cfg_cl = 2'd0;
    logic       wr_valid = 1'b0, wr_ap = 1'b0, rd_valid = 1'b0;
    logic [1:0] wr_bank = 2'd0, rd_bank = 2'd0;
    logic       wr_ready, rd_ready, cmd_wr, cmd_rd, dq_oe, rd_err;
    logic [1:0] cmd_bank, dm;
    int         errors = 0;
    int         checks = 0;

    always #2.5 clk = ~clk;

    wr_intr_rd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl),
        .wr_valid(wr_valid), .wr_ap(wr_ap), .wr_bank(wr_bank),
        .rd_valid(rd_valid), .rd_bank(rd_bank),
        .wr_ready(wr_ready), .rd_ready(rd_ready), .cmd_wr(cmd_wr),
        .cmd_rd(cmd_rd), .cmd_bank(cmd_bank), .dm(dm), .dq_oe(dq_oe),
        .rd_err(rd_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
        end
    endtask

    task automatic next_cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one write, read raised d cycles after it and held until issued
    task automatic run_case(input int bl, input int cl, input bit ap, input int d);
        int nc, clc, tt, rr;
        bit intr, rd_done;
        nc  = (bl == 0) ? 1 : (bl == 1) ? 2 : 4;
        clc = (cl == 0) ? 2 : 3;
        tt  = clc + nc;
        if (ap) rr = (d <= nc) ? nc + 1 : d;
        else    rr = (d < 2) ? 2 : d;
        intr = (rr <= nc);
        cfg_bl = 2'(bl); cfg_cl = 2'(cl); wr_ap = ap;
        wr_bank = 2'd1; rd_bank = 2'd2;
        rd_done = 1'b0;
        for (int c = 0; c <= rr + tt + 1; c++) begin
            wr_valid = (c == 0);
            rd_valid = (c >= d) && !rd_done;
            #1;
            if (c == 0)
                chk(cmd_wr == 1'b1, "R1 write issue", cmd_wr, 1);
            chk(cmd_rd == (c == rr), "R2/R3 read issue cycle", cmd_rd, (c == rr));
            chk(rd_err == (ap && d <= nc && c == d), "R6 error pulse", rd_err,
                (ap && d <= nc && c == d));
            if (c >= 1 && c <= nc) begin
                if (intr && c >= rr) begin
                    chk(dm == 2'b11, "R4 masked beats", dm, 3);
                    chk(dq_oe == 1'b0, "R5 released", dq_oe, 0);
                end else begin
                    chk(dm == 2'b00, "R1/R3 written beats", dm, 0);
                    chk(dq_oe == 1'b1, "R1/R3 driven", dq_oe, 1);
                end
            end else begin
                chk(dm == 2'b11, "R5 idle mask", dm, 3);
                chk(dq_oe == 1'b0, "R5 released", dq_oe, 0);
            end
            if (c == 1 && nc > 1)
                chk(rd_ready == 1'b0, "R2 read held after write", rd_ready, 0);
            if (c == rr)
                chk(cmd_bank == 2'd2, "R8 read bank", cmd_bank, 2);
            if (c == rr + tt)
                chk(wr_ready == 1'b0 && rd_ready == 1'b0, "R7 turnaround hold",
                    {wr_ready, rd_ready}, 0);
            if (c == rr + tt + 1)
                chk(wr_ready == 1'b1, "R7 back to idle", wr_ready, 1);
            if (cmd_rd) rd_done = 1'b1;
            next_cyc();
        end
        wr_valid = 1'b0;
        rd_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        @(negedge clk);
        next_cyc();
        #1;
        // R9: reset state
        chk(wr_ready && rd_ready, "R9 ready in reset", {wr_ready, rd_ready}, 3);
        chk(dm == 2'b11 && !dq_oe, "R9 mask in reset", {dm, dq_oe}, 6);
        chk(!cmd_wr && !cmd_rd && !rd_err, "R9 no strobes", {cmd_wr, cmd_rd, rd_err}, 0);
        rst_n = 1'b1;
        next_cyc();
        for (int bl = 0; bl < 3; bl++)
            for (int cl = 0; cl < 3; cl++)
                for (int ap = 0; ap < 2; ap++)
                    for (int d = 1; d <= ((bl == 0) ? 1 : (bl == 1) ? 2 : 4) + 1; d++)
                        run_case(bl, cl, ap[0], d);
        // R8: read beats write in idle
        cfg_bl = 2'd2; cfg_cl = 2'd1;
        wr_valid = 1'b1; rd_valid = 1'b1; rd_bank = 2'd3; wr_bank = 2'd0;
        #1;
        chk(cmd_rd == 1'b1 && cmd_wr == 1'b0, "R8 read priority", {cmd_rd, cmd_wr}, 2);
        chk(cmd_bank == 2'd3, "R8 bank on read", cmd_bank, 3);
        next_cyc();
        wr_valid = 1'b0; rd_valid = 1'b0;
        #1;
        chk(wr_ready == 1'b0, "R7 hold after idle read", wr_ready, 0);
        for (int k = 0; k < 20 && !wr_ready; k++) next_cyc();
        finish_run();
    end
endmodule